// File: doc/BRIEF.md
# Timer With Output Compare Channel

This block is a free-running counter of configurable width with one output compare channel. The counter advances only on cycles where the timer tick input is high, so an external prescaler sets its rate. An equality comparator checks the count against an active compare value. A match latches a compare flag, and the flag can raise an interrupt request. A waveform generator drives one output pin from the match events and from the TOP and BOTTOM points of the count.

Software reaches four registers through a small synchronous bus: a control register, the compare register, the flag register and a read-only view of the count. Four counting modes are available: normal wrap, phase-correct up/down PWM, clear-on-match, and single-slope (fast) PWM. In the two PWM modes a compare write lands in a buffer. That buffer is copied into the active compare value only at a fixed point of the count, so a PWM period never sees a half-updated threshold.

Top module: `tmr_cmp_unit`

## Requirements
- R1: After reset the count, the control register, the compare register and the flag read 0, and `wave_o` and `irq_o` are low.
- R2: The flag (bit 0 at address 2) rises on the second tick after a tick taken while the count equals the active compare value. It is still 0 after the tick that leaves the matching value and reads 1 after the next tick.
- R3: `irq_o` is high exactly when the flag, the interrupt enable (control bit 0) and `gie_i` are all set.
- R4: A pulse on `irq_ack_i` clears the flag. A bus write to address 2 with bit 0 set clears it, and a write with bit 0 clear leaves it set.
- R5: In fast PWM (control bits 2:1 = 11), compare writes go to the buffer, which reads back at address 1. The active value is loaded on the tick taken at count 0xFF, so it is in force from count 0.
- R6: In phase-correct PWM (control bits 2:1 = 01), the buffer is loaded into the active value on the upward tick taken at count 0xFE, so it is in force from TOP.
- R7: In normal mode (00) the count rises by one per tick, wraps from 0xFF to 0, and holds when no tick is given. A compare write takes effect at once.
- R8: In clear-on-match mode (10) the tick taken at the compare value returns the count to 0.
- R9: In phase-correct PWM the count runs 0 up to 0xFF, then down to 0, and then back up.
- R10: Compare-output field (control bits 4:3) 00 holds the pin low in every mode, and 01 holds it low in the PWM modes. In normal and clear-on-match modes, 01 toggles the pin on a match, 10 clears it and 11 sets it.
- R11: In fast PWM with field 10 the pin is high for OCR+1 of every 256 ticks (all 256 at 0xFF). With field 11 it is high for 255-OCR of them.
- R12: In phase-correct PWM with field 10 the pin is high for 2*OCR of every 510 ticks (0 at OCR 0, all 510 at 0xFF). With field 11 it is high for 510-2*OCR of them.
- R13: In non-PWM modes a pulse on `force_i` applies the match action to the pin without setting the flag or moving the count. In PWM modes it has no effect on the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timer tick enable; the count advances on clock edges where it is high |
| wr_en_i | input | 1 | Bus write strobe |
| addr_i | input | 2 | Register address: 0 control, 1 compare, 2 flag, 3 count |
| wdata_i | input | WIDTH | Bus write data |
| rdata_o | output | WIDTH | Combinational read data for `addr_i` |
| gie_i | input | 1 | Global interrupt enable |
| irq_ack_i | input | 1 | Interrupt acknowledge pulse; clears the flag |
| force_i | input | 1 | Force-compare strobe |
| irq_o | output | 1 | Compare interrupt request |
| wave_o | output | 1 | Waveform output pin |

## Verification
A wrong active compare value or a buffer commit at the wrong point changes the duty count. That change shows on `wave_o` within one PWM period (256 or 510 ticks), and the flag shows it two ticks after the expected match. A counter stepping in the wrong direction or clearing at the wrong value shows at once on the count readback. It also shifts the flag timing. A flag that sets on the match tick itself, or ignores a clear path, reads wrong within one tick of the event.

// File: rtl/tcu_pkg.sv
package tcu_pkg;

   typedef enum logic [1:0] {
      WM_NORMAL = 2'b00,
      WM_PHASE  = 2'b01,
      WM_CTC    = 2'b10,
      WM_FAST   = 2'b11
   } wmode_e;

   typedef enum logic [1:0] {
      CO_OFF    = 2'b00,
      CO_TOGGLE = 2'b01,
      CO_LOW    = 2'b10,
      CO_HIGH   = 2'b11
   } cmode_e;

   localparam logic [1:0] RA_CTRL = 2'd0;
   localparam logic [1:0] RA_CMP  = 2'd1;
   localparam logic [1:0] RA_FLAG = 2'd2;
   localparam logic [1:0] RA_CNT  = 2'd3;

   function automatic logic is_pwm(wmode_e m);
      return (m == WM_PHASE) || (m == WM_FAST);
   endfunction

endpackage

// File: rtl/tcu_counter.sv
module tcu_counter
   import tcu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  wmode_e           mode_i,
   input  logic [WIDTH-1:0] cmp_i,
   output logic [WIDTH-1:0] cnt_o,
   output logic             dir_up_o,
   output logic             at_top_o,
   output logic             at_bot_o
);
   localparam logic [WIDTH-1:0] ONE   = WIDTH'(1);
   localparam logic [WIDTH-1:0] MAXV  = {WIDTH{1'b1}};
   localparam logic [WIDTH-1:0] TOPM1 = MAXV - ONE;

   logic [WIDTH-1:0] cnt_q;
   logic             up_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         up_q  <= 1'b1;
      end else if (tick_i) begin
         unique case (mode_i)
            WM_CTC: begin
               cnt_q <= (cnt_q == cmp_i) ? '0 : cnt_q + ONE;
               up_q  <= 1'b1;
            end
            WM_PHASE: begin
               if (up_q) begin
                  cnt_q <= cnt_q + ONE;
                  if (cnt_q == TOPM1) up_q <= 1'b0;
               end else begin
                  cnt_q <= cnt_q - ONE;
                  if (cnt_q == ONE) up_q <= 1'b1;
               end
            end
            default: begin
               cnt_q <= cnt_q + ONE;
               up_q  <= 1'b1;
            end
         endcase
      end
   end

   assign cnt_o    = cnt_q;
   assign dir_up_o = up_q;
   assign at_top_o = (cnt_q == MAXV);
   assign at_bot_o = (cnt_q == '0);

endmodule

// File: rtl/tcu_compare.sv
module tcu_compare
   import tcu_pkg::*;
#(
   parameter int WIDTH      = 8,
   parameter bit PWM_BUFFER = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  wmode_e           mode_i,
   input  logic [WIDTH-1:0] cnt_i,
   input  logic             dir_up_i,
   input  logic             wr_i,
   input  logic [WIDTH-1:0] wdata_i,
   output logic [WIDTH-1:0] cmp_act_o,
   output logic [WIDTH-1:0] cmp_buf_o,
   output logic             match_o
);
   localparam logic [WIDTH-1:0] MAXV  = {WIDTH{1'b1}};
   localparam logic [WIDTH-1:0] TOPM1 = MAXV - WIDTH'(1);

   logic commit;
   assign commit = tick_i &&
                   (((mode_i == WM_FAST)  && (cnt_i == MAXV)) ||
                    ((mode_i == WM_PHASE) && dir_up_i && (cnt_i == TOPM1)));

   logic [WIDTH-1:0] act_q;

   generate
      if (PWM_BUFFER) begin : g_buffered
         logic [WIDTH-1:0] buf_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               buf_q <= '0;
               act_q <= '0;
            end else begin
               if (wr_i) buf_q <= wdata_i;
               if (wr_i && !is_pwm(mode_i)) act_q <= wdata_i;
               else if (commit)             act_q <= buf_q;
            end
         end
         assign cmp_buf_o = buf_q;
      end else begin : g_direct
         logic unused_commit;
         assign unused_commit = commit;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)   act_q <= '0;
            else if (wr_i) act_q <= wdata_i;
         end
         assign cmp_buf_o = act_q;
      end
   endgenerate

   assign cmp_act_o = act_q;
   assign match_o   = (cnt_i == act_q);

endmodule

// File: rtl/tcu_wavegen.sv
module tcu_wavegen
   import tcu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  wmode_e           mode_i,
   input  cmode_e           com_i,
   input  logic             match_i,
   input  logic             force_i,
   input  logic             at_top_i,
   input  logic             at_bot_i,
   input  logic             dir_up_i,
   input  logic [WIDTH-1:0] cmp_i,
   output logic             pin_o
);
   localparam logic [WIDTH-1:0] MAXV = {WIDTH{1'b1}};

   logic wave_q, wave_d, pwm;
   assign pwm = is_pwm(mode_i);

   always_comb begin
      wave_d = wave_q;
      if (!pwm) begin
         if ((tick_i && match_i) || force_i) begin
            unique case (com_i)
               CO_TOGGLE: wave_d = ~wave_q;
               CO_LOW:    wave_d = 1'b0;
               CO_HIGH:   wave_d = 1'b1;
               default:   wave_d = wave_q;
            endcase
         end
      end else if (tick_i) begin
         if (mode_i == WM_FAST) begin
            if (at_top_i)     wave_d = 1'b1;
            else if (match_i) wave_d = 1'b0;
         end else begin
            if (at_top_i)      wave_d = (cmp_i == MAXV);
            else if (at_bot_i) wave_d = (cmp_i != '0);
            else if (match_i)  wave_d = ~dir_up_i;
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) wave_q <= 1'b0;
      else         wave_q <= wave_d;
   end

   always_comb begin
      if (pwm) begin
         unique case (com_i)
            CO_LOW:  pin_o = wave_q;
            CO_HIGH: pin_o = ~wave_q;
            default: pin_o = 1'b0;
         endcase
      end else begin
         pin_o = (com_i == CO_OFF) ? 1'b0 : wave_q;
      end
   end

endmodule

// File: rtl/tmr_cmp_unit.sv
module tmr_cmp_unit
   import tcu_pkg::*;
#(
   parameter int WIDTH      = 8,
   parameter bit PWM_BUFFER = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic             wr_en_i,
   input  logic [1:0]       addr_i,
   input  logic [WIDTH-1:0] wdata_i,
   output logic [WIDTH-1:0] rdata_o,
   input  logic             gie_i,
   input  logic             irq_ack_i,
   input  logic             force_i,
   output logic             irq_o,
   output logic             wave_o
);
   generate
      if (WIDTH < 5) begin : g_bad_width
         $error("tmr_cmp_unit: WIDTH must be at least 5 to hold the control fields");
      end
   endgenerate

   logic             ie_q;
   wmode_e           mode_q;
   cmode_e           com_q;
   logic             pend_q, flag_q;
   logic [WIDTH-1:0] cnt, cmp_act, cmp_buf;
   logic             dir_up, at_top, at_bot, match;

   logic wr_ctrl, wr_cmp, flag_set, flag_clr;
   assign wr_ctrl  = wr_en_i && (addr_i == RA_CTRL);
   assign wr_cmp   = wr_en_i && (addr_i == RA_CMP);
   assign flag_set = tick_i && pend_q;
   assign flag_clr = irq_ack_i || (wr_en_i && (addr_i == RA_FLAG) && wdata_i[0]);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ie_q   <= 1'b0;
         mode_q <= WM_NORMAL;
         com_q  <= CO_OFF;
      end else if (wr_ctrl) begin
         ie_q   <= wdata_i[0];
         mode_q <= wmode_e'(wdata_i[2:1]);
         com_q  <= cmode_e'(wdata_i[4:3]);
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pend_q <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         if (tick_i) pend_q <= match;
         if (flag_set)      flag_q <= 1'b1;
         else if (flag_clr) flag_q <= 1'b0;
      end
   end

   tcu_counter #(.WIDTH(WIDTH)) u_cnt (
      .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .mode_i(mode_q),
      .cmp_i(cmp_act), .cnt_o(cnt), .dir_up_o(dir_up),
      .at_top_o(at_top), .at_bot_o(at_bot)
   );

   tcu_compare #(.WIDTH(WIDTH), .PWM_BUFFER(PWM_BUFFER)) u_cmp (
      .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .mode_i(mode_q),
      .cnt_i(cnt), .dir_up_i(dir_up), .wr_i(wr_cmp), .wdata_i(wdata_i),
      .cmp_act_o(cmp_act), .cmp_buf_o(cmp_buf), .match_o(match)
   );

   tcu_wavegen #(.WIDTH(WIDTH)) u_wave (
      .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .mode_i(mode_q),
      .com_i(com_q), .match_i(match), .force_i(force_i),
      .at_top_i(at_top), .at_bot_i(at_bot), .dir_up_i(dir_up),
      .cmp_i(cmp_act), .pin_o(wave_o)
   );

   always_comb begin
      rdata_o = '0;
      unique case (addr_i)
         RA_CTRL: begin
            rdata_o[0]   = ie_q;
            rdata_o[2:1] = mode_q;
            rdata_o[4:3] = com_q;
         end
         RA_CMP:  rdata_o    = cmp_buf;
         RA_FLAG: rdata_o[0] = flag_q;
         default: rdata_o    = cnt;
      endcase
   end

   assign irq_o = flag_q && ie_q && gie_i;

endmodule

// File: rtl/tcu_checker.sv
module tcu_checker
   import tcu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             tick_i,
   input logic             gie_i,
   input logic             irq_ack_i,
   input logic             irq_o,
   input wmode_e           mode_i,
   input logic [WIDTH-1:0] cnt_i,
   input logic             dir_up_i,
   input logic [WIDTH-1:0] cmp_act_i,
   input logic             pend_i,
   input logic             flag_i
);
   localparam logic [WIDTH-1:0] MAXV  = {WIDTH{1'b1}};
   localparam logic [WIDTH-1:0] TOPM1 = MAXV - WIDTH'(1);

   AST_FLAG_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_i) |-> $past(tick_i)); // R2
   AST_FLAG_AFTER_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_i) |-> $past(pend_i)); // R2
   AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> (gie_i && flag_i)); // R3
   AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_ack_i && !(tick_i && pend_i)) |=> !flag_i); // R4
   AST_PWM_CMP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!tick_i && is_pwm(mode_i)) |=> $stable(cmp_act_i)); // R5
   AST_CNT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_i |=> $stable(cnt_i)); // R7
   AST_CTC_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && mode_i == WM_CTC && cnt_i == cmp_act_i) |=> (cnt_i == '0)); // R8
   AST_PHASE_TURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && mode_i == WM_PHASE && cnt_i == MAXV && !dir_up_i) |=> (cnt_i == TOPM1)); // R9

endmodule

bind tmr_cmp_unit tcu_checker #(.WIDTH(WIDTH)) u_tcu_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .gie_i(gie_i),
   .irq_ack_i(irq_ack_i), .irq_o(irq_o), .mode_i(mode_q), .cnt_i(cnt),
   .dir_up_i(dir_up), .cmp_act_i(cmp_act), .pend_i(pend_q), .flag_i(flag_q)
);

// File: tb/test_tmr_cmp_unit.sv
module test_tmr_cmp_unit;
   localparam int CLK_PERIOD = 10;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tick = 1'b0;
   logic         wr_en = 1'b0;
   logic [1:0]   addr = 2'd0;
   logic [W-1:0] wdata = '0;
   logic [W-1:0] rdata;
   logic         gie = 1'b1;
   logic         ack = 1'b0;
   logic         frc = 1'b0;
   logic         irq, wave;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tmr_cmp_unit #(.WIDTH(W)) i_tmr_cmp_unit (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
      .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .gie_i(gie),
      .irq_ack_i(ack), .force_i(frc), .irq_o(irq), .wave_o(wave)
   );

   typedef struct packed {
      logic [1:0]  mode;
      logic [1:0]  com;
      logic [7:0]  ocr;
      logic [11:0] period;
      logic [11:0] high;
   } vec_t;

   // mode: 0 normal, 1 phase PWM, 2 clear-on-match, 3 fast PWM
   localparam int NVEC = 13;
   localparam vec_t TBL [NVEC] = '{
      '{2'd3, 2'd2, 8'h40, 12'd256, 12'd65},   // R11
      '{2'd3, 2'd3, 8'h40, 12'd256, 12'd191},  // R11
      '{2'd3, 2'd2, 8'hFF, 12'd256, 12'd256},  // R11
      '{2'd3, 2'd2, 8'h00, 12'd256, 12'd1},    // R11
      '{2'd1, 2'd2, 8'h80, 12'd510, 12'd256},  // R12
      '{2'd1, 2'd3, 8'h30, 12'd510, 12'd414},  // R12
      '{2'd1, 2'd2, 8'h00, 12'd510, 12'd0},    // R12
      '{2'd1, 2'd2, 8'hFF, 12'd510, 12'd510},  // R12
      '{2'd2, 2'd1, 8'h09, 12'd20,  12'd10},   // R10
      '{2'd2, 2'd3, 8'h09, 12'd20,  12'd20},   // R10
      '{2'd2, 2'd2, 8'h09, 12'd20,  12'd0},    // R10
      '{2'd0, 2'd0, 8'h10, 12'd256, 12'd0},    // R10
      '{2'd3, 2'd1, 8'h40, 12'd256, 12'd0}     // R10
   };

   task automatic check(input string tag, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0; ack = 1'b0; frc = 1'b0; gie = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output int v);
      @(negedge clk);
      addr = a;
      #1 v = int'(rdata);
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         tick = 1'b1;
      end
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic pulse_force();
      @(negedge clk); frc = 1'b1;
      @(negedge clk); frc = 1'b0;
   endtask

   function automatic logic [W-1:0] ctrl(input int ie, input int mode, input int com);
      return W'((com << 3) | (mode << 1) | ie);
   endfunction

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_run++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin : main
      int v;
      int hi;
      // R1: reset state
      do_reset();
      #1;
      check("R1 wave after reset", int'(wave), 0);
      check("R1 irq after reset", int'(irq), 0);
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), v);
         check("R1 register after reset", v, 0);
      end

      // table walk: R10 R11 R12
      for (int k = 0; k < NVEC; k++) begin
         do_reset();
         wr(2'd1, TBL[k].ocr);
         wr(2'd0, ctrl(0, TBL[k].mode, TBL[k].com));
         @(negedge clk);
         tick = 1'b1;
         repeat (1100) @(negedge clk);
         hi = 0;
         for (int c = 0; c < int'(TBL[k].period); c++) begin
            @(negedge clk);
            if (wave) hi++;
         end
         tick = 1'b0;
         check($sformatf("R10/R11/R12 duty vector %0d", k), hi, int'(TBL[k].high));
      end

      // R2 R7: flag timing, immediate write, counting
      do_reset();
      wr(2'd1, 8'd3);
      step(3);
      rd(2'd3, v); check("R7 count after 3 ticks", v, 3);
      rd(2'd2, v); check("R2 flag on match state", v, 0);
      step(1);
      rd(2'd2, v); check("R2 flag one tick after match", v, 0);
      step(1);
      rd(2'd2, v); check("R2 flag two ticks after match", v, 1);
      repeat (5) @(negedge clk);
      rd(2'd3, v); check("R7 count holds without tick", v, 5);

      // R3: interrupt gating
      #1 check("R3 irq with enable clear", int'(irq), 0);
      wr(2'd0, ctrl(1, 0, 0));
      #1 check("R3 irq all set", int'(irq), 1);
      @(negedge clk); gie = 1'b0;
      #1 check("R3 irq global off", int'(irq), 0);
      @(negedge clk); gie = 1'b1;

      // R4: clear paths
      wr(2'd2, 8'h00);
      rd(2'd2, v); check("R4 write zero keeps flag", v, 1);
      @(negedge clk); ack = 1'b1;
      @(negedge clk); ack = 1'b0;
      rd(2'd2, v); check("R4 ack clears flag", v, 0);
      step(251);
      rd(2'd3, v); check("R7 count wraps to 0", v, 0);
      step(5);
      rd(2'd2, v); check("R2 flag again after wrap", v, 1);
      wr(2'd2, 8'h01);
      rd(2'd2, v); check("R4 write one clears flag", v, 0);

      // R8: clear-on-match
      do_reset();
      wr(2'd1, 8'd4);
      wr(2'd0, ctrl(0, 2, 0));
      step(4);
      rd(2'd3, v); check("R8 count at compare", v, 4);
      step(1);
      rd(2'd3, v); check("R8 count cleared", v, 0);

      // R9: up/down count
      do_reset();
      wr(2'd0, ctrl(0, 1, 0));
      step(255);
      rd(2'd3, v); check("R9 reaches top", v, 255);
      step(1);
      rd(2'd3, v); check("R9 turns down", v, 254);
      step(254);
      rd(2'd3, v); check("R9 reaches bottom", v, 0);
      step(1);
      rd(2'd3, v); check("R9 turns up", v, 1);

      // R5: fast PWM buffer commit at bottom
      do_reset();
      wr(2'd1, 8'd5);
      wr(2'd0, ctrl(0, 3, 0));
      wr(2'd1, 8'd9);
      rd(2'd1, v); check("R5 buffer readback", v, 9);
      step(7);
      rd(2'd2, v); check("R5 old value still active", v, 1);
      wr(2'd2, 8'h01);
      step(248);
      rd(2'd2, v); check("R5 no match before wrap", v, 0);
      step(8);
      rd(2'd2, v); check("R5 old value gone after commit", v, 0);
      step(4);
      rd(2'd2, v); check("R5 new value active from bottom", v, 1);

      // R6: phase PWM buffer commit at top
      do_reset();
      wr(2'd1, 8'd5);
      wr(2'd0, ctrl(0, 1, 0));
      wr(2'd1, 8'd9);
      step(7);
      rd(2'd2, v); check("R6 old value active going up", v, 1);
      wr(2'd2, 8'h01);
      step(248);
      rd(2'd3, v); check("R6 count at top", v, 255);
      step(248);
      rd(2'd2, v); check("R6 new value matched going down", v, 1);

      // R13: force strobe
      do_reset();
      wr(2'd0, ctrl(0, 0, 1));
      pulse_force();
      #1 check("R13 force toggles pin", int'(wave), 1);
      rd(2'd2, v); check("R13 force leaves flag", v, 0);
      rd(2'd3, v); check("R13 force leaves count", v, 0);
      pulse_force();
      #1 check("R13 second force toggles back", int'(wave), 0);
      wr(2'd0, ctrl(0, 3, 3));
      #1 check("R13 inverting pin before force", int'(wave), 1);
      pulse_force();
      #1 check("R13 force ignored in PWM", int'(wave), 1);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule